// File: doc/BRIEF.md
# Timed Step Pulse Sequencer

The block produces the step and direction signals for one stepper motor channel. It runs from a 4 MHz system clock. A frame-sync strobe starts each sequence. On a rising edge of that strobe, with the channel enabled, the block runs through four phases in a fixed order. It first holds off for a programmed start delay. It then holds off for a programmed drive-settle delay. Next it emits a burst of step pulses at a programmed period. Finally it returns to idle. Direction is presented on its own output and stays constant for the whole sequence. A busy flag is high from the start of the sequence until the block is idle again.

Both delays count in coarse units of 8 µs, which is 32 system clocks. The pulse period counts in single clocks of 0.25 µs. The pulse count is programmed in pairs: a count field of N yields 2N pulses. Every configuration input is captured when a sequence starts. A processor may therefore rewrite the settings at any time without disturbing the burst that is already running.

Top module: `step_seq`

## Requirements
- R1: While reset is asserted and after its release, `step_o`, `dir_o` and `busy_o` are low until a sequence starts.
- R2: A start needs two things at the same clock edge: `frame_sync` is sampled high after having been low on the previous edge, and `cfg_enable` is 1. `busy_o` rises on that edge. If `cfg_enable` is 0 at that edge, the rise is ignored and `busy_o` stays low.
- R3: After a start, the start wait lasts `cfg_start_wait`×PRESCALE clocks and the drive wait then lasts `cfg_drive_wait`×PRESCALE clocks, so the first step appears (start+drive)×PRESCALE clocks after `busy_o` rises. PRESCALE defaults to 32, which is 8 µs at 4 MHz.
- R4: With count field N > 0 and period P clocks, the burst holds 2N periods of P clocks each. `busy_o` falls exactly (start+drive)×PRESCALE + 2N×P clocks after it rose.
- R5: In each period, `step_o` is high for the first max(1, floor(P/2)) clocks and low for the rest. For P = 1 this means `step_o` stays high through the whole burst.
- R6: A count field of 0 produces no step at all. `busy_o` then falls after the two waits alone.
- R7: A rising `frame_sync` while `busy_o` is high has no effect on the running sequence. A `frame_sync` level that is still held high when the block becomes idle does not start a new sequence.
- R8: `dir_o` takes the value of `cfg_dir` at the start edge (1 = one rotation sense, 0 = the other). It holds that value through the sequence and afterwards, until the next start.
- R9: A start or drive wait of 0 behaves as 1 unit, and a period of 0 behaves as 1 clock.
- R10: Changes to `cfg_dir`, `cfg_count`, `cfg_period`, `cfg_start_wait` or `cfg_drive_wait` during a sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_sync | input | 1 | Frame-sync strobe; its rising edge starts a sequence |
| cfg_enable | input | 1 | Channel on (1) or off (0) |
| cfg_dir | input | 1 | Rotation sense to present on `dir_o` |
| cfg_count | input | COUNT_W (6) | Pulse pairs per sequence |
| cfg_period | input | PERIOD_W (15) | Step period in clocks |
| cfg_start_wait | input | WAIT_W (8) | Start delay in prescaler units |
| cfg_drive_wait | input | WAIT_W (8) | Drive-settle delay in prescaler units |
| step_o | output | 1 | Step pulse train |
| dir_o | output | 1 | Latched direction |
| busy_o | output | 1 | High while a sequence runs |

## Verification
Different internal faults show up at the ports in different ways:

- A corrupted phase or unit counter moves the first step edge away from (start+drive)×PRESCALE clocks, or stretches the `busy_o` window. This becomes visible within one sequence, as soon as the burst begins or ends.
- A fault in the period or pulse counter changes how many clocks `step_o` stays high in each period, or how many rising edges the burst contains. This shows up at the first faulty period.
- A latch that reloads mid-sequence shows up as `dir_o` moving while `busy_o` is high, or as a burst length that follows the rewritten inputs.

The bench sweeps counts, periods and waits, including the 0 and 1 corner values. For each run it compares the busy length, the total high time, the number of step edges and the first-step offset with arithmetic expectations.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DRIVE = 2'd2,
    PH_BURST = 2'd3
  } phase_e;

endpackage

// File: rtl/step_prescale.sv
module step_prescale #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr || cnt_q == LAST) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  assign tick = !clr && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/step_phase_ctrl.sv
module step_phase_ctrl
  import step_seq_pkg::*;
#(
  parameter int WAIT_W   = 8,
  parameter int PERIOD_W = 15,
  parameter int COUNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                cfg_dir,
  input  logic [COUNT_W-1:0]  cfg_count,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [WAIT_W-1:0]   cfg_start_wait,
  input  logic [WAIT_W-1:0]   cfg_drive_wait,
  input  logic                unit_tick,
  input  logic                burst_done,
  output phase_e              phase,
  output logic                pre_clr,
  output logic                dir_q,
  output logic [PERIOD_W-1:0] period_q,
  output logic [COUNT_W:0]    total_q
);
  localparam logic [WAIT_W-1:0]   W_ONE = WAIT_W'(1);
  localparam logic [PERIOD_W-1:0] P_ONE = PERIOD_W'(1);

  phase_e             phase_q, phase_d;
  logic [WAIT_W-1:0]  unit_q, unit_d;
  logic [WAIT_W-1:0]  sw_q, dw_q;
  logic               load_en;
  logic               sw_last, dw_last;

  assign sw_last = (unit_q == sw_q - W_ONE);
  assign dw_last = (unit_q == dw_q - W_ONE);

  always_comb begin
    phase_d = phase_q;
    unit_d  = unit_q;
    load_en = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_req) begin
          phase_d = PH_START;
          unit_d  = '0;
          load_en = 1'b1;
        end
      end
      PH_START: begin
        if (unit_tick) begin
          if (sw_last) begin
            phase_d = PH_DRIVE;
            unit_d  = '0;
          end else begin
            unit_d = unit_q + W_ONE;
          end
        end
      end
      PH_DRIVE: begin
        if (unit_tick) begin
          if (dw_last) begin
            phase_d = (total_q == '0) ? PH_IDLE : PH_BURST;
            unit_d  = '0;
          end else begin
            unit_d = unit_q + W_ONE;
          end
        end
      end
      default: begin
        if (burst_done) phase_d = PH_IDLE;
      end
    endcase
  end

  assign pre_clr = (phase_q != PH_START) && (phase_q != PH_DRIVE);
  assign phase   = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      unit_q  <= '0;
    end else begin
      phase_q <= phase_d;
      unit_q  <= unit_d;
    end
  end

  // configuration captured only on the start edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      period_q <= P_ONE;
      total_q  <= '0;
      sw_q     <= W_ONE;
      dw_q     <= W_ONE;
    end else if (load_en) begin
      dir_q    <= cfg_dir;
      period_q <= (cfg_period == '0) ? P_ONE : cfg_period;
      total_q  <= {cfg_count, 1'b0};
      sw_q     <= (cfg_start_wait == '0) ? W_ONE : cfg_start_wait;
      dw_q     <= (cfg_drive_wait == '0) ? W_ONE : cfg_drive_wait;
    end
  end
endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen #(
  parameter int PERIOD_W = 15,
  parameter int COUNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  input  logic [COUNT_W:0]    total,
  output logic                step,
  output logic                done
);
  localparam logic [PERIOD_W-1:0] P_ONE = PERIOD_W'(1);
  localparam logic [COUNT_W:0]    C_ONE = (COUNT_W+1)'(1);

  logic [PERIOD_W-1:0] ph_q, ph_d;
  logic [COUNT_W:0]    pc_q, pc_d;
  logic [PERIOD_W-1:0] half, high_len;
  logic                end_per;

  assign half     = period >> 1;
  assign high_len = (half == '0) ? P_ONE : half;
  assign end_per  = (ph_q == period - P_ONE);
  assign done     = run && end_per && (pc_q == total - C_ONE);
  assign step     = run && (ph_q < high_len);

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    if (!run) begin
      ph_d = '0;
      pc_d = '0;
    end else if (end_per) begin
      ph_d = '0;
      pc_d = pc_q + C_ONE;
    end else begin
      ph_d = ph_q + P_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      pc_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
    end
  end
endmodule

// File: rtl/step_seq.sv
module step_seq
  import step_seq_pkg::*;
#(
  parameter int PRESCALE = 32,
  parameter int WAIT_W   = 8,
  parameter int PERIOD_W = 15,
  parameter int COUNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_sync,
  input  logic                cfg_enable,
  input  logic                cfg_dir,
  input  logic [COUNT_W-1:0]  cfg_count,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [WAIT_W-1:0]   cfg_start_wait,
  input  logic [WAIT_W-1:0]   cfg_drive_wait,
  output logic                step_o,
  output logic                dir_o,
  output logic                busy_o
);
  logic                fs_q;
  logic                start_req;
  logic                unit_tick, pre_clr, burst_done;
  phase_e              phase;
  logic [PERIOD_W-1:0] period_q;
  logic [COUNT_W:0]    total_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_q <= 1'b0;
    else        fs_q <= frame_sync;
  end

  assign start_req = frame_sync && !fs_q && cfg_enable;

  step_prescale #(.DIV(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pre_clr),
    .tick  (unit_tick)
  );

  step_phase_ctrl #(
    .WAIT_W   (WAIT_W),
    .PERIOD_W (PERIOD_W),
    .COUNT_W  (COUNT_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_req      (start_req),
    .cfg_dir        (cfg_dir),
    .cfg_count      (cfg_count),
    .cfg_period     (cfg_period),
    .cfg_start_wait (cfg_start_wait),
    .cfg_drive_wait (cfg_drive_wait),
    .unit_tick      (unit_tick),
    .burst_done     (burst_done),
    .phase          (phase),
    .pre_clr        (pre_clr),
    .dir_q          (dir_o),
    .period_q       (period_q),
    .total_q        (total_q)
  );

  step_pulse_gen #(
    .PERIOD_W (PERIOD_W),
    .COUNT_W  (COUNT_W)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (phase == PH_BURST),
    .period (period_q),
    .total  (total_q),
    .step   (step_o),
    .done   (burst_done)
  );

  assign busy_o = (phase != PH_IDLE);
endmodule

// File: rtl/step_seq_chk.sv
module step_seq_chk
  import step_seq_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   frame_sync,
  input logic   cfg_enable,
  input logic   step_o,
  input logic   dir_o,
  input logic   busy_o,
  input phase_e phase
);
  // R2: busy only rises after a sampled strobe with the channel enabled
  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(frame_sync) && $past(cfg_enable)));

  // R2: leaving idle always goes to the start wait
  p_idle_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_IDLE && phase != PH_IDLE) |-> phase == PH_START);

  // R3: the start wait is always followed by the drive wait
  p_start_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_START && phase != PH_START) |-> phase == PH_DRIVE);

  // R6: after the drive wait only the burst or idle can follow
  p_drive_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_DRIVE && phase != PH_DRIVE) |-> phase != PH_START);

  // R7: a burst ends in idle, never restarts on a strobe
  p_burst_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == PH_BURST && phase != PH_BURST) |-> phase == PH_IDLE);

  // R5: steps appear only during the burst
  p_step_in_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (busy_o && phase == PH_BURST));

  // R8: direction frozen while the sequence runs
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(dir_o));
endmodule

bind step_seq step_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_sync (frame_sync),
  .cfg_enable (cfg_enable),
  .step_o     (step_o),
  .dir_o      (dir_o),
  .busy_o     (busy_o),
  .phase      (phase)
);

// File: tb/sim_step_seq.sv
module sim_step_seq;
  localparam int PS = 4;

  logic        clk;
  logic        rst_n;
  logic        frame_sync;
  logic        cfg_enable;
  logic        cfg_dir;
  logic [5:0]  cfg_count;
  logic [14:0] cfg_period;
  logic [7:0]  cfg_start_wait;
  logic [7:0]  cfg_drive_wait;
  logic        step_o, dir_o, busy_o;

  int n_tests = 0;
  int n_fail  = 0;

  step_seq #(.PRESCALE(PS)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_sync     (frame_sync),
    .cfg_enable     (cfg_enable),
    .cfg_dir        (cfg_dir),
    .cfg_count      (cfg_count),
    .cfg_period     (cfg_period),
    .cfg_start_wait (cfg_start_wait),
    .cfg_drive_wait (cfg_drive_wait),
    .step_o         (step_o),
    .dir_o          (dir_o),
    .busy_o         (busy_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one sequence; perturb rewrites inputs and pulses the strobe mid-run
  task automatic run_seq(input bit en, input bit dir, input int n, input int p,
                         input int sw, input int dw, input bit perturb, input string tag);
    int swe, dwe, pe, hi, lw, bl, exp_hi, exp_rise, exp_first;
    int busy_n, high_n, rise_n, first, dir_err;
    bit prev;
    swe = (sw == 0) ? 1 : sw;
    dwe = (dw == 0) ? 1 : dw;
    pe  = (p == 0) ? 1 : p;
    hi  = (pe / 2 == 0) ? 1 : pe / 2;
    lw  = (swe + dwe) * PS;
    bl  = en ? lw + 2 * n * pe : 0;
    exp_hi    = en ? 2 * n * hi : 0;
    exp_rise  = (!en || n == 0) ? 0 : ((pe == 1) ? 1 : 2 * n);
    exp_first = (!en || n == 0) ? -1 : lw;
    @(negedge clk);
    cfg_enable = en; cfg_dir = dir; cfg_count = 6'(n); cfg_period = 15'(p);
    cfg_start_wait = 8'(sw); cfg_drive_wait = 8'(dw);
    frame_sync = 1'b1;
    busy_n = 0; high_n = 0; rise_n = 0; first = -1; dir_err = 0; prev = 1'b0;
    for (int i = 0; i < bl + 6; i++) begin
      @(negedge clk);
      if (i == 0) frame_sync = 1'b0;
      if (perturb && i == 2) begin
        frame_sync = 1'b1;
        cfg_dir = ~dir; cfg_count = 6'(n + 5); cfg_period = 15'(p + 3);
        cfg_start_wait = 8'(sw + 2); cfg_drive_wait = 8'(dw + 2);
      end
      if (perturb && i == 3) frame_sync = 1'b0;
      if (busy_o) busy_n++;
      if (step_o) high_n++;
      if (step_o && !prev) begin
        rise_n++;
        if (first < 0) first = i;
      end
      if (busy_o && dir_o != dir) dir_err++;
      prev = step_o;
    end
    chk(busy_n == bl, {tag, " R4 busy length"}, busy_n, bl);
    chk(high_n == exp_hi, {tag, " R5 step high clocks"}, high_n, exp_hi);
    chk(rise_n == exp_rise, {tag, " R4 step edges"}, rise_n, exp_rise);
    chk(first == exp_first, {tag, " R3 first step offset"}, first, exp_first);
    chk(dir_err == 0, {tag, " R8 dir held"}, dir_err, 0);
  endtask

  initial begin
    int ns[5] = '{0, 1, 2, 3, 63};
    int pp[5] = '{1, 2, 3, 5, 8};
    int sws[3] = '{1, 2, 7};
    int dws[2] = '{1, 3};
    rst_n = 1'b0; frame_sync = 1'b0; cfg_enable = 1'b0; cfg_dir = 1'b0;
    cfg_count = '0; cfg_period = 15'd1; cfg_start_wait = 8'd1; cfg_drive_wait = 8'd1;
    repeat (3) @(negedge clk);
    chk(!step_o && !dir_o && !busy_o, "R1 outputs in reset", {step_o, dir_o, busy_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!step_o && !dir_o && !busy_o, "R1 outputs after reset", {step_o, dir_o, busy_o}, 0);

    // R2: channel disabled ignores the strobe
    run_seq(1'b0, 1'b1, 2, 3, 1, 1, 1'b0, "R2 disabled");
    chk(dir_o == 1'b0, "R2 dir untouched when disabled", dir_o, 0);

    // sweep over count, period and waits (R3 R4 R5 R6)
    foreach (ns[a]) foreach (pp[b]) foreach (sws[c]) foreach (dws[d])
      run_seq(1'b1, 1'((a + b + c) % 2), ns[a], pp[b], sws[c], dws[d], 1'b0, "sweep");

    // R6: zero count, waits only
    run_seq(1'b1, 1'b1, 0, 9, 4, 2, 1'b0, "R6 zero count");
    // R3: maximum start wait
    run_seq(1'b1, 1'b0, 1, 4, 255, 255, 1'b0, "R3 long waits");
    // R9: zero waits and zero period
    run_seq(1'b1, 1'b1, 3, 0, 0, 0, 1'b0, "R9 zero values");
    // R7 R10: strobe and rewritten inputs mid-sequence
    run_seq(1'b1, 1'b1, 2, 6, 1, 2, 1'b1, "R7 R10 mid-run changes");
    chk(dir_o == 1'b1, "R8 dir kept after sequence", dir_o, 1);

    // R7: strobe held high across the end does not retrigger
    @(negedge clk);
    cfg_enable = 1'b1; cfg_count = 6'd1; cfg_period = 15'd2;
    cfg_start_wait = 8'd1; cfg_drive_wait = 8'd1; frame_sync = 1'b1;
    repeat (2 * PS + 4 + 10) @(negedge clk);
    chk(!busy_o, "R7 held strobe no retrigger", busy_o, 0);
    frame_sync = 1'b0;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule